// File: doc/BRIEF.md
# Three-Channel LED PWM Dimmer

The block produces three dimming waveforms for LED strings. In internal mode a free-running period counter builds each waveform from a 14-bit duty word and a divider factor K. K has a 4-bit integer part and an 8-bit fraction, so the period is K groups of 2^GROUP_LOG2 clocks. The fraction is realised by an accumulator: on average the period is exact, while each single period is a whole number of groups. In direct mode the three external PWM pins pass straight through to the channels. A separate per-string enable forces a channel low in both modes.

The duty word, the divider and the phase-spread choice are sampled only at the start of each period, so a setting never changes in the middle of a pulse. The duty word reaches the generator through a shadow register. That register either follows the inputs every cycle or loads only while the VSYNC pin sits at its active level. When phase spread is on, the windows of channels 2 and 3 start a third and two thirds of the way into the period. A combined all-low output lets a sleep timer elsewhere see that every channel is idle.

Top module: `led_pwm_dimmer`

## Requirements
- R1: With mode_int_i = 0, each pwm_o[k] equals ext_pwm_i[k] AND str_en_i[k] in the same cycle, with no register on the path.
- R2: In internal mode each period lasts (div_int_i + 1 + c) * 2^GROUP_LOG2 clocks. Here c is the carry out of an 8-bit accumulator that adds div_frac_i once per period. Any 256 consecutive periods therefore total (256*(div_int_i+1) + div_frac_i) groups.
- R3: When div_int_i is all ones (K = 16), div_frac_i is ignored and every period lasts exactly 16 groups.
- R4: The active duty D is {duty_hi_i[7:0], duty_lo_i[5:0]}, with duty_hi_i as bits 13..6. For a period of L clocks, channel 1 is high for the first floor(L*D/16384) clocks of the period.
- R5: D = 0 gives a constant low output, and D = 3FFFh gives a constant high output.
- R6: A nonzero D whose high time would be shorter than MIN_PULSE clocks is stretched to MIN_PULSE clocks.
- R7: With spread_i = 1 at the period start, the high windows of channels 2 and 3 begin floor(L/3) and floor(2L/3) clocks into the period and wrap around its end. With spread_i = 0, all three channels are identical.
- R8: With sync_en_i = 0, the shadow duty register follows the duty inputs every cycle. The new value takes effect at the next period start.
- R9: With sync_en_i = 1, the shadow duty loads only while vsync_i is high (sync_low_i = 0) or low (sync_low_i = 1). Otherwise the old duty keeps being generated.
- R10: str_en_i[k] = 0 forces pwm_o[k] low in both modes.
- R11: all_low_o is 1 exactly when all three pwm_o bits are 0.
- R12: During reset the internal outputs are low and the shadow duty is 0. The first period starts at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | generator clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| mode_int_i | input | 1 | 1: internal generator, 0: external pins |
| spread_i | input | 1 | 1: 120-degree spacing of channels |
| sync_en_i | input | 1 | 1: duty loads gated by vsync_i |
| sync_low_i | input | 1 | 1: vsync_i active low |
| vsync_i | input | 1 | frame sync level |
| duty_hi_i | input | 8 | duty bits 13..6 |
| duty_lo_i | input | 6 | duty bits 5..0 |
| div_int_i | input | 4 | integer part of K minus one |
| div_frac_i | input | 8 | fraction of K in 1/256 |
| str_en_i | input | 3 | per-string enable |
| ext_pwm_i | input | 3 | external dimming inputs |
| pwm_o | output | 3 | channel dimming outputs |
| all_low_o | output | 1 | all channels low |

## Verification
The bench builds the block with GROUP_LOG2 = 2 and MIN_PULSE = 3, so a period spans 4 to 64 clocks. This makes it possible to compare every cycle of several whole periods for eight duty values, four divider settings and both phase modes, including the clamped K = 16 case and the stretched minimum pulse. A separate measurement checks that rising edges 40 clocks apart over four periods confirm the fractional average. Direct mode is swept over all 64 pin and enable combinations. Both VSYNC polarities are exercised in holding and loading phases.

// File: rtl/pwm_dim_pkg.sv
package pwm_dim_pkg;
  localparam int NUM_CH    = 3;
  localparam int DUTY_W    = 14;
  localparam int DUTY_LO_W = 6;
  localparam int DUTY_HI_W = DUTY_W - DUTY_LO_W;
  localparam int INT_W     = 4;
  localparam int FRAC_W    = 8;

  typedef logic [DUTY_W-1:0] duty_t;

  typedef struct packed {
    logic [INT_W-1:0]  whole;
    logic [FRAC_W-1:0] frac;
  } div_cfg_t;
endpackage

// File: rtl/pwm_dim_shadow.sv
module pwm_dim_shadow
  import pwm_dim_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sync_en_i,
  input  logic  sync_low_i,
  input  logic  vsync_i,
  input  duty_t duty_i,
  output duty_t duty_o
);
  duty_t duty_q;
  logic  load;

  assign load = !sync_en_i || (vsync_i ^ sync_low_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   duty_q <= '0;
    else if (load) duty_q <= duty_i;
  end

  assign duty_o = duty_q;

  // R9
  vsync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_en_i && (vsync_i == sync_low_i)) |=> $stable(duty_o));
endmodule

// File: rtl/pwm_dim_period.sv
module pwm_dim_period
  import pwm_dim_pkg::*;
#(
  parameter int GROUP_LOG2 = 10,
  parameter int MIN_PULSE  = 14,
  localparam int CNT_W     = INT_W + GROUP_LOG2 + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  duty_t            duty_i,
  input  div_cfg_t         div_i,
  input  logic             spread_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] len_o,
  output logic [CNT_W-1:0] thr_o,
  output logic [CNT_W-1:0] off1_o,
  output logic [CNT_W-1:0] off2_o
);
  localparam int PROD_W = CNT_W + DUTY_W;

  logic [CNT_W-1:0]  cnt_q, len_q, thr_q, off1_q, off2_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] frac_eff;
  logic [FRAC_W:0]   acc_sum;
  logic [INT_W:0]    groups;
  logic [CNT_W-1:0]  len_d, thr_raw, thr_d, off1_d, off2_d;
  logic [PROD_W-1:0] prod;
  logic [CNT_W:0]    twice;
  logic              wrap;

  assign wrap = (cnt_q == len_q - 1'b1);

  always_comb begin
    frac_eff = (&div_i.whole) ? '0 : div_i.frac;   // K clamps at 16
    acc_sum  = {1'b0, acc_q} + {1'b0, frac_eff};
    groups   = {1'b0, div_i.whole} + (INT_W+1)'(1) + (INT_W+1)'(acc_sum[FRAC_W]);
    len_d    = CNT_W'(groups) << GROUP_LOG2;
    prod     = PROD_W'(len_d) * PROD_W'(duty_i);
    thr_raw  = CNT_W'(prod >> DUTY_W);
    if (duty_i == '0)                     thr_d = '0;
    else if (&duty_i)                     thr_d = len_d;
    else if (thr_raw < CNT_W'(MIN_PULSE)) thr_d = CNT_W'(MIN_PULSE);
    else                                  thr_d = thr_raw;
    twice  = {len_d, 1'b0};
    off1_d = spread_i ? len_d / CNT_W'(3) : '0;
    off2_d = spread_i ? CNT_W'(twice / (CNT_W+1)'(3)) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      len_q  <= CNT_W'(1);
      thr_q  <= '0;
      off1_q <= '0;
      off2_q <= '0;
      acc_q  <= '0;
    end else if (wrap) begin
      cnt_q  <= '0;
      len_q  <= len_d;
      thr_q  <= thr_d;
      off1_q <= off1_d;
      off2_q <= off2_d;
      acc_q  <= acc_sum[FRAC_W-1:0];
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign len_o  = len_q;
  assign thr_o  = thr_q;
  assign off1_o = off1_q;
  assign off2_o = off2_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < len_q);
  // R2
  group_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (len_q[GROUP_LOG2-1:0] == '0 && len_q != '0));
  // R4
  thr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_q <= len_q);
  // R6
  min_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_q != '0) |-> (thr_q >= CNT_W'(MIN_PULSE)));
endmodule

// File: rtl/pwm_dim_chan.sv
module pwm_dim_chan #(
  parameter int CNT_W = 15
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic [CNT_W-1:0] off_i,
  output logic             pwm_o
);
  logic [CNT_W:0] pos;

  always_comb begin
    if (cnt_i >= off_i) pos = {1'b0, cnt_i - off_i};
    else                pos = {1'b0, cnt_i} + {1'b0, len_i} - {1'b0, off_i};
    pwm_o = (pos < {1'b0, thr_i});
  end
endmodule

// File: rtl/led_pwm_dimmer.sv
module led_pwm_dimmer
  import pwm_dim_pkg::*;
#(
  parameter int GROUP_LOG2 = 10,
  parameter int MIN_PULSE  = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_int_i,
  input  logic                 spread_i,
  input  logic                 sync_en_i,
  input  logic                 sync_low_i,
  input  logic                 vsync_i,
  input  logic [DUTY_HI_W-1:0] duty_hi_i,
  input  logic [DUTY_LO_W-1:0] duty_lo_i,
  input  logic [INT_W-1:0]     div_int_i,
  input  logic [FRAC_W-1:0]    div_frac_i,
  input  logic [NUM_CH-1:0]    str_en_i,
  input  logic [NUM_CH-1:0]    ext_pwm_i,
  output logic [NUM_CH-1:0]    pwm_o,
  output logic                 all_low_o
);
  localparam int CNT_W = INT_W + GROUP_LOG2 + 1;

  duty_t            duty_act;
  div_cfg_t         div_cfg;
  logic [CNT_W-1:0] cnt, len, thr;
  logic [CNT_W-1:0] off [NUM_CH];
  logic [NUM_CH-1:0] int_pwm;

  assign div_cfg = '{whole: div_int_i, frac: div_frac_i};
  assign off[0]  = '0;

  pwm_dim_shadow i_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_en_i (sync_en_i),
    .sync_low_i(sync_low_i),
    .vsync_i   (vsync_i),
    .duty_i    ({duty_hi_i, duty_lo_i}),
    .duty_o    (duty_act)
  );

  pwm_dim_period #(.GROUP_LOG2(GROUP_LOG2), .MIN_PULSE(MIN_PULSE)) i_period (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .duty_i  (duty_act),
    .div_i   (div_cfg),
    .spread_i(spread_i),
    .cnt_o   (cnt),
    .len_o   (len),
    .thr_o   (thr),
    .off1_o  (off[1]),
    .off2_o  (off[2])
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    pwm_dim_chan #(.CNT_W(CNT_W)) i_chan (
      .cnt_i(cnt),
      .len_i(len),
      .thr_i(thr),
      .off_i(off[k]),
      .pwm_o(int_pwm[k])
    );

    assign pwm_o[k] = str_en_i[k] & (mode_int_i ? int_pwm[k] : ext_pwm_i[k]);

    // R10
    str_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !str_en_i[k] |-> !pwm_o[k]);
  end

  assign all_low_o = ~|pwm_o;

  // R5
  zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr == '0) |-> (int_pwm == '0));
endmodule

// File: tb/test_led_pwm_dimmer.sv
`timescale 1ns/1ps
module test_led_pwm_dimmer;
  localparam int GL   = 2;
  localparam int G    = 1 << GL;
  localparam int MINP = 3;

  logic       clk = 0, rst_ni = 0;
  logic       mode_int = 0, spread = 0, sync_en = 0, sync_low = 0, vsync = 0;
  logic [7:0] duty_hi = 0;
  logic [5:0] duty_lo = 0;
  logic [3:0] div_int = 0;
  logic [7:0] div_frac = 0;
  logic [2:0] str_en = 3'b111, ext_pwm = 0;
  logic [2:0] pwm;
  logic       all_low;

  int checks = 0, errors = 0;
  string req = "R12";

  led_pwm_dimmer #(.GROUP_LOG2(GL), .MIN_PULSE(MINP)) i_led_pwm_dimmer (
    .clk_i(clk), .rst_ni(rst_ni), .mode_int_i(mode_int), .spread_i(spread),
    .sync_en_i(sync_en), .sync_low_i(sync_low), .vsync_i(vsync),
    .duty_hi_i(duty_hi), .duty_lo_i(duty_lo), .div_int_i(div_int),
    .div_frac_i(div_frac), .str_en_i(str_en), .ext_pwm_i(ext_pwm),
    .pwm_o(pwm), .all_low_o(all_low)
  );

  always #2 clk = ~clk;

  // reference period tracker
  int m_cnt, m_len, m_thr, m_acc, m_duty;
  int m_off [3];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_len = 1; m_thr = 0; m_acc = 0; m_duty = 0;
      m_off[0] = 0; m_off[1] = 0; m_off[2] = 0;
    end else begin
      if (m_cnt == m_len - 1) begin
        int f, s, raw;
        f = (div_int == 4'hF) ? 0 : int'(div_frac);
        s = m_acc + f;
        m_acc = s % 256;
        m_len = (int'(div_int) + 1 + s / 256) * G;
        raw = (m_len * m_duty) / 16384;
        if (m_duty == 0)          m_thr = 0;
        else if (m_duty == 16383) m_thr = m_len;
        else if (raw < MINP)      m_thr = MINP;
        else                      m_thr = raw;
        m_off[0] = 0;
        m_off[1] = spread ? m_len / 3 : 0;
        m_off[2] = spread ? (2 * m_len) / 3 : 0;
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
      if (!sync_en || (vsync != sync_low)) m_duty = {duty_hi, duty_lo};
    end
  end

  function automatic logic [2:0] expect_pwm();
    logic [2:0] e;
    for (int k = 0; k < 3; k++) begin
      if (!mode_int) e[k] = ext_pwm[k] & str_en[k];
      else e[k] = str_en[k] && (((m_cnt + m_len - m_off[k]) % m_len) < m_thr);
    end
    return e;
  endfunction

  task automatic check_now();
    logic [2:0] e;
    e = expect_pwm();
    checks++;
    if (pwm !== e) begin
      errors++;
      $display("FAIL %s pwm actual %b expected %b (cnt %0d len %0d)", req, pwm, e, m_cnt, m_len);
    end
    checks++;
    if (all_low !== (e == 3'b000)) begin
      errors++;
      $display("FAIL R11 all_low actual %b expected %b", all_low, (e == 3'b000));
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
    end
  endtask

  task automatic set_duty(input int d);
    duty_hi = d[13:6];
    duty_lo = d[5:0];
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  int duties [8] = '{0, 1, 16'h0100, 16'h1555, 16'h2000, 16'h3000, 16'h3FFE, 16'h3FFF};
  int dints  [4] = '{0, 1, 3, 15};
  int dfracs [4] = '{0, 8'h80, 8'h40, 8'hFF};

  initial begin
    // R12: reset state, internal mode held low
    mode_int = 1;
    set_duty(16'h2000);
    repeat (3) @(negedge clk);
    req = "R12"; check_now();
    rst_ni = 1;
    step(20);   // R12: duty 0 until shadow loads, then first periods

    // R1, R10: direct pass-through sweep
    mode_int = 0;
    for (int p = 0; p < 8; p++)
      for (int e = 0; e < 8; e++) begin
        ext_pwm = p[2:0]; str_en = e[2:0];
        req = (e == 7) ? "R1" : "R10";
        step(1);
      end
    str_en = 3'b111; ext_pwm = 0;

    // R2..R8: internal sweep
    mode_int = 1;
    for (int s = 0; s < 2; s++)
      for (int v = 0; v < 4; v++)
        for (int d = 0; d < 8; d++) begin
          spread = s[0];
          div_int = dints[v][3:0]; div_frac = dfracs[v][7:0];
          set_duty(duties[d]);
          if (s == 1)                                req = "R7";
          else if (v == 3)                           req = "R3";
          else if (d == 1)                           req = "R6";
          else if (d == 0 || d == 7)                 req = "R5";
          else if (v == 1 || v == 2)                 req = "R2";
          else                                       req = "R4_R8";
          step(150);
        end

    // R2: fractional average, four periods of K = 2.5 total 40 clocks
    spread = 0; div_int = 1; div_frac = 8'h80; set_duty(16'h2000);
    req = "R2";
    step(40);
    begin
      int t0, rises, tnow;
      logic prev;
      prev = pwm[0]; rises = 0; t0 = 0; tnow = 0;
      while (rises < 5 && tnow < 200) begin
        @(negedge clk); tnow++;
        if (pwm[0] && !prev) begin
          if (rises == 0) t0 = tnow;
          rises++;
        end
        prev = pwm[0];
      end
      checks++;
      if (tnow - t0 != 40) begin
        errors++;
        $display("FAIL R2 four-period span actual %0d expected 40", tnow - t0);
      end
    end

    // R10: string enable in internal mode
    str_en = 3'b101; set_duty(16'h3FFF); spread = 1;
    req = "R10"; step(60);
    str_en = 3'b111;

    // R9: VSYNC gating, active high then active low
    spread = 0; div_int = 0; div_frac = 0;
    set_duty(0); step(20);
    sync_en = 1; sync_low = 0; vsync = 0;
    set_duty(16'h3FFF);
    req = "R9"; step(30);
    checks++;
    if (all_low !== 1'b1) begin
      errors++;
      $display("FAIL R9 held duty all_low actual %b expected 1", all_low);
    end
    vsync = 1; step(30);
    checks++;
    if (pwm !== 3'b111) begin
      errors++;
      $display("FAIL R9 loaded duty pwm actual %b expected 111", pwm);
    end
    sync_low = 1; set_duty(16'h1000); step(30);   // vsync high is inactive now
    vsync = 0; step(30);
    sync_en = 0; set_duty(16'h0800);
    req = "R8"; step(30);

    finish_run();
  end
endmodule